// File: doc/BRIEF.md
# Video Memory Write Port with Address Remapping

This block sits between a byte-wide register write bus and a word-wide video memory. Software programs a control register, loads a word address one byte at a time, and then streams data bytes into a low-lane register and a high-lane register. Each data-byte write becomes one registered write on the memory side. The write carries a byte-lane enable, and its address comes from the stored word address after a selectable bit permutation.

The permutation lets linear CPU writes fill tile data stored for 2, 4 or 8 bits per pixel. In each case a low field of the address is rotated left by three bit positions, so the three row bits move to the bottom. The stored address itself is never permuted. After the write selected as the trigger, it advances in its plain form by a step of 1, 32 or 128 words. The trigger is either the low-lane data write or the high-lane data write.

Top module: `vram_port_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, the control fields and the stored address are zero and no memory write is issued. The first low-lane data write then targets address 0x0000.
- R2: Select 1 loads bits 7:0 of the stored address and select 2 loads bits 15:8. Neither load causes an increment.
- R3: A write to select 3 (low data) issues exactly one write strobe in the following cycle. It has lane enable 2'b01 and the byte on data bits 7:0, with bits 15:8 zero.
- R4: A write to select 4 (high data) issues exactly one write strobe in the following cycle. It has lane enable 2'b10 and the byte on data bits 15:8, with bits 7:0 zero.
- R5: Control bits 1:0 choose the step that is added to the stored address: code 0 adds 1, code 1 adds 32, and codes 2 and 3 add 128.
- R6: Control bit 7 chooses the trigger. With 0, only low-data writes increment the address. With 1, only high-data writes increment it. The write that triggers the increment uses the address from before the increment.
- R7: With control bits 3:2 = 0, the memory address equals the stored address.
- R8: With control bits 3:2 = 1, address bits 7:0 are rotated left by 3 and bits 15:8 pass through.
- R9: With control bits 3:2 = 2, bits 8:0 are rotated left by 3 and bits 15:9 pass through. With code 3, bits 9:0 are rotated left by 3 and bits 15:10 pass through.
- R10: The stored address increments in plain form whatever the remap code. A later switch to code 0 exposes the plain incremented value.
- R11: The stored address wraps modulo 2^16 on increment.
- R12: Control bits 6:4 have no effect. Writes to selects 5 to 7 change neither the registers nor the memory side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select: 0 control, 1 address low, 2 address high, 3 data low, 4 data high |
| wr_data_i | input | 8 | Register write byte |
| vram_we_o | output | 1 | Memory write strobe, one cycle per data write |
| vram_be_o | output | 2 | Memory byte-lane enables |
| vram_addr_o | output | 16 | Remapped memory word address |
| vram_wdata_o | output | 16 | Memory write data, with the byte in its lane |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit lanes and steps of 32 and 128. With these values a handful of writes takes the stored address across the 0xFFFF boundary, with both the unit step and the 128-word step. Every remap code is applied to the same running address, so the rotated fields can be checked against hand-computed values. Returning to the plain mode then shows that the stored address never took the permuted form.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_ALO  = 3'd1,
    SEL_AHI  = 3'd2,
    SEL_DLO  = 3'd3,
    SEL_DHI  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/vram_addr_step.sv
module vram_addr_step #(
  parameter int ADDR_W   = 16,
  parameter int STEP_MID = 32,
  parameter int STEP_BIG = 128
) (
  input  logic [1:0]        code_i,
  output logic [ADDR_W-1:0] step_o
);
  always_comb begin
    unique case (code_i)
      2'd0:    step_o = ADDR_W'(1);
      2'd1:    step_o = ADDR_W'(STEP_MID);
      default: step_o = ADDR_W'(STEP_BIG);
    endcase
  end
endmodule

// File: rtl/vram_addr_remap.sv
module vram_addr_remap #(
  parameter int ADDR_W = 16,
  parameter int BASE_W = 8,
  parameter int ROT    = 3
) (
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] map_w [4];

  assign map_w[0] = addr_i;

  for (genvar m = 1; m < 4; m++) begin : g_map
    localparam int LW = BASE_W + m - 1;
    // rotate the low LW bits left by ROT, keep the rest
    assign map_w[m] = {addr_i[ADDR_W-1:LW], addr_i[LW-ROT-1:0], addr_i[LW-1:LW-ROT]};
  end

  assign addr_o = map_w[mode_i];
endmodule

// File: rtl/vram_port_ctrl.sv
module vram_port_ctrl
  import vram_port_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int STEP_MID = 32,
  parameter int STEP_BIG = 128,
  parameter int BASE_W   = 8,
  parameter int ROT      = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [2:0]          wr_sel_i,
  input  logic [BYTE_W-1:0]   wr_data_i,
  output logic                vram_we_o,
  output logic [1:0]          vram_be_o,
  output logic [2*BYTE_W-1:0] vram_addr_o,
  output logic [2*BYTE_W-1:0] vram_wdata_o
);
  localparam int ADDR_W = 2 * BYTE_W;

  logic [1:0]        step_code_q;
  logic [1:0]        remap_q;
  logic              trig_hi_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] step_w;
  logic [ADDR_W-1:0] mapped_w;

  vram_addr_step #(
    .ADDR_W  (ADDR_W),
    .STEP_MID(STEP_MID),
    .STEP_BIG(STEP_BIG)
  ) i_step (
    .code_i(step_code_q),
    .step_o(step_w)
  );

  vram_addr_remap #(
    .ADDR_W(ADDR_W),
    .BASE_W(BASE_W),
    .ROT   (ROT)
  ) i_remap (
    .mode_i(remap_q),
    .addr_i(addr_q),
    .addr_o(mapped_w)
  );

  logic wr_lo, wr_hi;
  assign wr_lo = wr_en_i && (wr_sel_i == SEL_DLO);
  assign wr_hi = wr_en_i && (wr_sel_i == SEL_DHI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_code_q  <= '0;
      remap_q      <= '0;
      trig_hi_q    <= 1'b0;
      addr_q       <= '0;
      vram_we_o    <= 1'b0;
      vram_be_o    <= '0;
      vram_addr_o  <= '0;
      vram_wdata_o <= '0;
    end else begin
      vram_we_o <= 1'b0;
      vram_be_o <= '0;
      if (wr_en_i) begin
        unique case (wr_sel_i)
          SEL_CTRL: begin
            step_code_q <= wr_data_i[1:0];
            remap_q     <= wr_data_i[3:2];
            trig_hi_q   <= wr_data_i[BYTE_W-1];
          end
          SEL_ALO: addr_q[BYTE_W-1:0]      <= wr_data_i;
          SEL_AHI: addr_q[ADDR_W-1:BYTE_W] <= wr_data_i;
          SEL_DLO: begin
            vram_we_o    <= 1'b1;
            vram_be_o    <= 2'b01;
            vram_addr_o  <= mapped_w;
            vram_wdata_o <= {{BYTE_W{1'b0}}, wr_data_i};
            if (!trig_hi_q) addr_q <= addr_q + step_w;
          end
          SEL_DHI: begin
            vram_we_o    <= 1'b1;
            vram_be_o    <= 2'b10;
            vram_addr_o  <= mapped_w;
            vram_wdata_o <= {wr_data_i, {BYTE_W{1'b0}}};
            if (trig_hi_q) addr_q <= addr_q + step_w;
          end
          default: ;
        endcase
      end
    end
  end

  p_one_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vram_we_o |-> $countones(vram_be_o) == 1);

  p_inc_trig_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_lo && !trig_hi_q) || (wr_hi && trig_hi_q)) |=> addr_q == $past(addr_q) + $past(step_w));

  p_hold_other_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_lo && trig_hi_q) || (wr_hi && !trig_hi_q)) |=> $stable(addr_q));

  p_load_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_ALO) |=> addr_q[ADDR_W-1:BYTE_W] == $past(addr_q[ADDR_W-1:BYTE_W]));

  p_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_lo || wr_hi) && remap_q == 2'd0) |=> vram_addr_o == $past(addr_q));

  p_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_lo || wr_hi) |=> !vram_we_o);
endmodule

// File: tb/test_vram_port_ctrl.sv
module test_vram_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        we;
  logic [1:0]  be;
  logic [15:0] addr;
  logic [15:0] wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vram_port_ctrl i_vram_port_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .vram_we_o(we), .vram_be_o(be),
    .vram_addr_o(addr), .vram_wdata_o(wdata)
  );

  // {sel, data, exp_we, exp_be, exp_addr, exp_wdata}
  localparam int NV = 33;
  localparam logic [45:0] VEC [NV] = '{
    {3'd0, 8'h00, 1'b0, 2'b00, 16'h0000, 16'h0000},  // ctrl 0
    {3'd1, 8'h34, 1'b0, 2'b00, 16'h0000, 16'h0000},  // R2
    {3'd2, 8'h12, 1'b0, 2'b00, 16'h0000, 16'h0000},  // R2
    {3'd3, 8'hAA, 1'b1, 2'b01, 16'h1234, 16'h00AA},  // R2 R3
    {3'd4, 8'h55, 1'b1, 2'b10, 16'h1235, 16'h5500},  // R4 R6
    {3'd3, 8'h01, 1'b1, 2'b01, 16'h1235, 16'h0001},  // R6
    {3'd0, 8'h81, 1'b0, 2'b00, 16'h0000, 16'h0000},  // trig hi, step 32
    {3'd3, 8'h02, 1'b1, 2'b01, 16'h1236, 16'h0002},  // R6
    {3'd4, 8'h03, 1'b1, 2'b10, 16'h1236, 16'h0300},  // R6
    {3'd3, 8'h04, 1'b1, 2'b01, 16'h1256, 16'h0004},  // R5
    {3'd0, 8'h04, 1'b0, 2'b00, 16'h0000, 16'h0000},  // remap 1
    {3'd3, 8'h05, 1'b1, 2'b01, 16'h12B2, 16'h0005},  // R8
    {3'd0, 8'h08, 1'b0, 2'b00, 16'h0000, 16'h0000},  // remap 2
    {3'd3, 8'h06, 1'b1, 2'b01, 16'h12B9, 16'h0006},  // R9
    {3'd0, 8'h0C, 1'b0, 2'b00, 16'h0000, 16'h0000},  // remap 3
    {3'd3, 8'h07, 1'b1, 2'b01, 16'h12C4, 16'h0007},  // R9
    {3'd0, 8'h72, 1'b0, 2'b00, 16'h0000, 16'h0000},  // bits 6:4 set, step 128
    {3'd3, 8'h08, 1'b1, 2'b01, 16'h1259, 16'h0008},  // R10 R7
    {3'd3, 8'h09, 1'b1, 2'b01, 16'h12D9, 16'h0009},  // R5 R12
    {3'd5, 8'hFF, 1'b0, 2'b00, 16'h0000, 16'h0000},  // R12
    {3'd7, 8'h00, 1'b0, 2'b00, 16'h0000, 16'h0000},  // R12
    {3'd3, 8'h0A, 1'b1, 2'b01, 16'h1359, 16'h000A},  // R12
    {3'd1, 8'hC0, 1'b0, 2'b00, 16'h0000, 16'h0000},
    {3'd2, 8'hFF, 1'b0, 2'b00, 16'h0000, 16'h0000},
    {3'd3, 8'h0B, 1'b1, 2'b01, 16'hFFC0, 16'h000B},  // R11
    {3'd3, 8'h0C, 1'b1, 2'b01, 16'h0040, 16'h000C},  // R11
    {3'd0, 8'h00, 1'b0, 2'b00, 16'h0000, 16'h0000},
    {3'd1, 8'hFF, 1'b0, 2'b00, 16'h0000, 16'h0000},
    {3'd2, 8'hFF, 1'b0, 2'b00, 16'h0000, 16'h0000},
    {3'd3, 8'h0D, 1'b1, 2'b01, 16'hFFFF, 16'h000D},  // R11
    {3'd0, 8'h03, 1'b0, 2'b00, 16'h0000, 16'h0000},  // step code 3
    {3'd3, 8'h0E, 1'b1, 2'b01, 16'h0000, 16'h000E},  // R11 R5
    {3'd3, 8'h0F, 1'b1, 2'b01, 16'h0080, 16'h000F}   // R5
  };

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act we/be/addr/wdata=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {we, be, addr, wdata}, 35'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {we, be, addr, wdata}, 35'd0);
    wr(3'd4, 8'h9C);
    check("R1 R4 first high write", {we, be, addr, wdata}, {1'b1, 2'b10, 16'h0000, 16'h9C00});
    wr(3'd3, 8'h11);
    check("R1 R6 no inc from high", {we, be, addr, wdata}, {1'b1, 2'b01, 16'h0000, 16'h0011});
    @(negedge clk);
    check("R3 strobe single cycle", {we, be}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][45:43], VEC[i][42:35]);
      if (VEC[i][34])
        check($sformatf("vector %0d", i), {we, be, addr, wdata}, VEC[i][34:0]);
      else
        check($sformatf("vector %0d no strobe", i), {34'd0, we}, 35'd0);
    end

    // mid-run reset clears control and address
    wr(3'd0, 8'h8D);
    wr(3'd1, 8'h77);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 async reset", {we, be, addr, wdata}, 35'd0);
    rst_n = 1'b1;
    wr(3'd3, 8'h42);
    check("R1 state cleared", {we, be, addr, wdata}, {1'b1, 2'b01, 16'h0000, 16'h0042});
    wr(3'd3, 8'h43);
    check("R1 R5 step back to 1", {we, be, addr, wdata}, {1'b1, 2'b01, 16'h0001, 16'h0043});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule